// File: doc/BRIEF.md
# Virtual Interrupt List Register File

This block keeps the per-CPU list of virtual interrupts that a hypervisor has placed in front of a guest. Each physical CPU owns `NUM_LR` 32-bit entries. An entry carries a virtual ID, a linked physical ID, a 5-bit priority, a 2-bit state, a group flag and a hardware-link flag. The hypervisor writes and reads entries by CPU and index. The guest side of the interrupt controller presents a virtual CPU number and a virtual ID, and the block answers at once with the matching entry's index, priority, group and physical ID.

The same lookup drives the guest's state changes. An acknowledge drops the pending bit, set-active raises the active bit and a deactivate drops it. When a deactivated entry is linked to a physical interrupt, the block forwards a filtered deactivate request toward the distributor one cycle later. The request carries a CPU mask: one CPU for private interrupts, all CPUs for shared ones.

Top module: `virq_list_regs`

## Requirements
- R1: After reset every entry reads 0, `deact_valid` is 0 and a lookup misses.
- R2: A write stores `wr_data & 32'hFF8F_FFFF`, so bits 22:20 are always 0. `rd_data` shows entry (`rd_cpu`, `rd_idx`) combinationally, and a write is visible from the cycle after its clock edge.
- R3: Entry fields are: virtual ID in bits 9:0, physical ID in bits 19:10, state in bits 29:28, priority in bits 27:23, group-1 flag in bit 30 and hardware-link flag in bit 31. A lookup uses real CPU = `op_vcpu - NUM_CPU`, and only `op_vcpu` in [NUM_CPU, 2*NUM_CPU) is valid. It hits on the lowest-indexed entry whose virtual ID equals `op_virq` and whose state is not 0 (invalid). `lk_idx` is that index.
- R4: On a hit, `lk_prio` is the 5-bit priority followed by three zero bits, and `lk_grp1` is bit 30. On a miss, `lk_prio`, `lk_grp1` and `lk_phys_id` are all 0.
- R5: `eoi_ok` is 1 when any entry of the addressed CPU has a matching virtual ID and state bit 29 (active) set. This holds even if that entry is not the first match. `eoi_ok` is 0 for a non-virtual CPU number.
- R6: `op_kind` encodings are: 1 acknowledge (clears bit 28), 2 set-active (sets bit 29), 3 deactivate (clears bit 29), 0 none. The change applies to the hit entry at the next clock edge.
- R7: An operation that misses changes no entry and forwards nothing.
- R8: A deactivate that hits an entry with bit 31 set raises `deact_valid` for one cycle after the edge, with `deact_irq` equal to the physical ID. This happens only when SGI_COUNT (16) <= ID < MAX_IRQ (1020) and either `sec_en` is 0 or `phys_grp1` is 1.
- R9: `deact_mask` is the one-hot bit of the real CPU when the physical ID is below INTERNAL_COUNT (32). For any higher ID it is all ones.
- R10: When a write and an operation hit the same entry in one cycle, the written value is stored and the operation is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Hypervisor entry write strobe |
| wr_cpu | input | CPU_W | Physical CPU of the written entry |
| wr_idx | input | LR_W | Entry index to write |
| wr_data | input | 32 | Entry value (masked on store) |
| rd_cpu | input | CPU_W | Physical CPU of the read entry |
| rd_idx | input | LR_W | Entry index to read |
| rd_data | output | 32 | Entry value read back |
| op_kind | input | 2 | Guest operation: 0 none, 1 ack, 2 set-active, 3 deactivate |
| op_vcpu | input | VCPU_W | Virtual CPU number of the lookup |
| op_virq | input | 10 | Virtual ID looked up |
| sec_en | input | 1 | Security extensions enabled |
| phys_grp1 | input | 1 | Distributor: `lk_phys_id` is group 1 for this CPU |
| lk_hit | output | 1 | Lookup matched a live entry |
| lk_idx | output | LR_W | Index of the first live match |
| lk_prio | output | 8 | Expanded priority of the match |
| lk_grp1 | output | 1 | Group-1 flag of the match |
| lk_phys_id | output | 10 | Physical ID of the match |
| eoi_ok | output | 1 | An active entry with this virtual ID exists |
| deact_valid | output | 1 | Forwarded physical deactivate pulse |
| deact_irq | output | 10 | Physical interrupt to deactivate |
| deact_mask | output | NUM_CPU | CPUs whose active bit is cleared |

## Verification
The hardest case to reach is the difference between the first live match and the entry that makes a deactivate valid. It needs two entries with the same virtual ID, a pending-only one at a lower index and an active one above it, and it needs them in a CPU that the lookup addresses. The stimulus preloads exactly that pair. It then acknowledges the lower entry so that it turns invalid, and shows the lookup moving to the upper one with a different priority. The filter for the forwarded deactivate is reached with hardware-linked entries whose physical IDs sit below the SGI range, at the upper limit, and in the private and shared ranges, and the security flag is toggled on a repeatedly reactivated entry.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam int ENT_W = 32;
  localparam int ID_W  = 10;

  typedef logic [ENT_W-1:0] lr_entry_t;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_ACK     = 2'd1,
    OP_SET_ACT = 2'd2,
    OP_CLR_ACT = 2'd3
  } lr_op_e;

  // defined fields: 31:23 and 19:0; 22:20 reserved
  localparam lr_entry_t WR_MASK = 32'hFF8F_FFFF;
  localparam int PEND_BIT = 28;
  localparam int ACT_BIT  = 29;

  function automatic logic [ID_W-1:0] virt_id(input lr_entry_t e);
    return e[9:0];
  endfunction

  function automatic logic [ID_W-1:0] phys_id(input lr_entry_t e);
    return e[19:10];
  endfunction

  function automatic logic [1:0] lr_state(input lr_entry_t e);
    return e[29:28];
  endfunction

  function automatic logic [7:0] prio8(input lr_entry_t e);
    return {e[27:23], 3'b000};
  endfunction

  function automatic logic is_grp1(input lr_entry_t e);
    return e[30];
  endfunction

  function automatic logic is_hw(input lr_entry_t e);
    return e[31];
  endfunction

  function automatic lr_entry_t apply_op(input lr_entry_t e, input lr_op_e op);
    lr_entry_t r;
    r = e;
    case (op)
      OP_ACK:     r[PEND_BIT] = 1'b0;
      OP_SET_ACT: r[ACT_BIT]  = 1'b1;
      OP_CLR_ACT: r[ACT_BIT]  = 1'b0;
      default:    r = e;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vlr_store.sv
module vlr_store
  import vlr_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_LR  = 4,
  parameter int CPU_W   = 1,
  parameter int LR_W    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [CPU_W-1:0]                     wr_cpu,
  input  logic [LR_W-1:0]                      wr_idx,
  input  lr_entry_t                            wr_data,
  input  logic                                 upd_en,
  input  logic [CPU_W-1:0]                     upd_cpu,
  input  logic [LR_W-1:0]                      upd_idx,
  input  lr_op_e                               upd_op,
  output lr_entry_t [NUM_CPU-1:0][NUM_LR-1:0]  ent_q
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar l = 0; l < NUM_LR; l++) begin : g_lr
      logic wr_sel, upd_sel;
      assign wr_sel  = wr_en  && (wr_cpu  == CPU_W'(c)) && (wr_idx  == LR_W'(l));
      assign upd_sel = upd_en && (upd_cpu == CPU_W'(c)) && (upd_idx == LR_W'(l));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ent_q[c][l] <= '0;
        else if (wr_sel)  ent_q[c][l] <= wr_data & WR_MASK;
        else if (upd_sel) ent_q[c][l] <= apply_op(ent_q[c][l], upd_op);
      end
    end
  end

  // ---------------- checks ----------------
  logic             same_tgt;
  logic             chk_upd, chk_wr;
  lr_op_e           chk_op;
  logic [CPU_W-1:0] chk_cpu, chk_wcpu;
  logic [LR_W-1:0]  chk_idx, chk_widx;
  lr_entry_t        chk_wdata;

  assign same_tgt = wr_en && (wr_cpu == upd_cpu) && (wr_idx == upd_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_upd <= 1'b0; chk_wr <= 1'b0; chk_op <= OP_NONE;
      chk_cpu <= '0; chk_idx <= '0; chk_wcpu <= '0; chk_widx <= '0; chk_wdata <= '0;
    end else begin
      chk_upd   <= upd_en && !same_tgt;
      chk_op    <= upd_op;
      chk_cpu   <= upd_cpu;
      chk_idx   <= upd_idx;
      chk_wr    <= wr_en;
      chk_wcpu  <= wr_cpu;
      chk_widx  <= wr_idx;
      chk_wdata <= wr_data & WR_MASK;
    end
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr |-> ent_q[chk_wcpu][chk_widx] == chk_wdata);
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_upd && chk_op == OP_ACK) |-> !ent_q[chk_cpu][chk_idx][PEND_BIT]);
  p_set_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_upd && chk_op == OP_SET_ACT) |-> ent_q[chk_cpu][chk_idx][ACT_BIT]);
  p_clr_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_upd && chk_op == OP_CLR_ACT) |-> !ent_q[chk_cpu][chk_idx][ACT_BIT]);
endmodule

// File: rtl/vlr_match.sv
module vlr_match
  import vlr_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int LR_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  lr_entry_t [NUM_LR-1:0] row,
  input  logic [ID_W-1:0]        virq,
  output logic                   hit,
  output logic [LR_W-1:0]        idx,
  output lr_entry_t              sel,
  output logic                   eoi_ok
);
  logic [NUM_LR-1:0] live_m, act_m;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_cmp
    logic id_eq;
    assign id_eq     = (virt_id(row[g]) == virq);
    assign live_m[g] = id_eq && (lr_state(row[g]) != 2'd0);
    assign act_m[g]  = id_eq && row[g][ACT_BIT];
  end

  always_comb begin
    idx = '0;
    for (int i = NUM_LR - 1; i >= 0; i--) begin
      if (live_m[i]) idx = LR_W'(i);
    end
  end

  assign hit    = en && (|live_m);
  assign sel    = row[idx];
  assign eoi_ok = en && (|act_m);

  // R3: no live match below the chosen index
  p_first_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((live_m & ((NUM_LR'(1) << idx) - NUM_LR'(1))) == '0));
  p_hit_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lr_state(sel) != 2'd0 && virt_id(sel) == virq));
endmodule

// File: rtl/vlr_deact.sv
module vlr_deact
  import vlr_pkg::*;
#(
  parameter int NUM_CPU        = 2,
  parameter int CPU_W          = 1,
  parameter int SGI_COUNT      = 16,
  parameter int INTERNAL_COUNT = 32,
  parameter int MAX_IRQ        = 1020
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  lr_entry_t          ent,
  input  logic [CPU_W-1:0]   cpu,
  input  logic               sec_en,
  input  logic               phys_grp1,
  output logic               deact_valid,
  output logic [ID_W-1:0]    deact_irq,
  output logic [NUM_CPU-1:0] deact_mask
);
  localparam logic [ID_W-1:0] SGI_L = ID_W'(SGI_COUNT);
  localparam logic [ID_W-1:0] INT_L = ID_W'(INTERNAL_COUNT);
  localparam logic [ID_W-1:0] MAX_L = ID_W'(MAX_IRQ);

  logic [ID_W-1:0] pid;
  logic            in_range, sec_pass, fwd;

  assign pid      = phys_id(ent);
  assign in_range = (pid >= SGI_L) && (pid < MAX_L);
  assign sec_pass = !sec_en || phys_grp1;
  assign fwd      = req && is_hw(ent) && in_range && sec_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deact_valid <= 1'b0;
      deact_irq   <= '0;
      deact_mask  <= '0;
    end else begin
      deact_valid <= fwd;
      deact_irq   <= pid;
      deact_mask  <= (pid < INT_L) ? (NUM_CPU'(1) << cpu) : '1;
    end
  end

  p_deact_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> $past(req && is_hw(ent)));
  p_deact_secure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> $past(!sec_en || phys_grp1));
  p_deact_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> (deact_irq >= SGI_L && deact_irq < MAX_L));
  p_mask_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> ($countones(deact_mask) == 1 || deact_mask == '1));
endmodule

// File: rtl/virq_list_regs.sv
module virq_list_regs
  import vlr_pkg::*;
#(
  parameter int NUM_CPU        = 2,
  parameter int NUM_LR         = 4,
  parameter int SGI_COUNT      = 16,
  parameter int INTERNAL_COUNT = 32,
  parameter int MAX_IRQ        = 1020,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int LR_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
  localparam int VCPU_W = $clog2(2 * NUM_CPU)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CPU_W-1:0]   wr_cpu,
  input  logic [LR_W-1:0]    wr_idx,
  input  logic [31:0]        wr_data,
  input  logic [CPU_W-1:0]   rd_cpu,
  input  logic [LR_W-1:0]    rd_idx,
  output logic [31:0]        rd_data,
  input  logic [1:0]         op_kind,
  input  logic [VCPU_W-1:0]  op_vcpu,
  input  logic [9:0]         op_virq,
  input  logic               sec_en,
  input  logic               phys_grp1,
  output logic               lk_hit,
  output logic [LR_W-1:0]    lk_idx,
  output logic [7:0]         lk_prio,
  output logic               lk_grp1,
  output logic [9:0]         lk_phys_id,
  output logic               eoi_ok,
  output logic               deact_valid,
  output logic [9:0]         deact_irq,
  output logic [NUM_CPU-1:0] deact_mask
);
  lr_entry_t [NUM_CPU-1:0][NUM_LR-1:0] ent_q;
  lr_entry_t [NUM_LR-1:0]              row;
  lr_entry_t                           sel;
  lr_op_e                              op;
  logic [VCPU_W-1:0]                   vdiff;
  logic [CPU_W-1:0]                    real_cpu;
  logic                                is_virt, upd_en, clr_req;

  assign op       = lr_op_e'(op_kind);
  assign is_virt  = (op_vcpu >= VCPU_W'(NUM_CPU)) && ({1'b0, op_vcpu} < (VCPU_W + 1)'(2 * NUM_CPU));
  assign vdiff    = op_vcpu - VCPU_W'(NUM_CPU);
  assign real_cpu = vdiff[CPU_W-1:0];
  assign row      = ent_q[real_cpu];
  assign rd_data  = ent_q[rd_cpu][rd_idx];

  vlr_store #(.NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR), .CPU_W(CPU_W), .LR_W(LR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_idx(wr_idx), .wr_data(wr_data),
    .upd_en(upd_en), .upd_cpu(real_cpu), .upd_idx(lk_idx), .upd_op(op),
    .ent_q(ent_q)
  );

  vlr_match #(.NUM_LR(NUM_LR), .LR_W(LR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .en(is_virt), .row(row), .virq(op_virq),
    .hit(lk_hit), .idx(lk_idx), .sel(sel), .eoi_ok(eoi_ok)
  );

  assign upd_en     = lk_hit && (op != OP_NONE);
  assign clr_req    = lk_hit && (op == OP_CLR_ACT);
  assign lk_prio    = lk_hit ? prio8(sel)   : 8'd0;
  assign lk_grp1    = lk_hit ? is_grp1(sel) : 1'b0;
  assign lk_phys_id = lk_hit ? phys_id(sel) : '0;

  vlr_deact #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .SGI_COUNT(SGI_COUNT),
              .INTERNAL_COUNT(INTERNAL_COUNT), .MAX_IRQ(MAX_IRQ)) u_deact (
    .clk(clk), .rst_n(rst_n), .req(clr_req), .ent(sel), .cpu(real_cpu),
    .sec_en(sec_en), .phys_grp1(phys_grp1),
    .deact_valid(deact_valid), .deact_irq(deact_irq), .deact_mask(deact_mask)
  );

  // R7: an op from a non-virtual CPU number never reaches the store
  p_phys_cpu_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_virt |-> (!lk_hit && !eoi_ok));
endmodule

// File: tb/virq_list_regs_bench.sv
module virq_list_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_cpu = '0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [0:0]  rd_cpu = '0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [1:0]  op_kind = '0;
  logic [1:0]  op_vcpu = 2'd2;
  logic [9:0]  op_virq = '0;
  logic        sec_en = 1'b0;
  logic        phys_grp1 = 1'b0;
  logic        lk_hit, lk_grp1, eoi_ok, deact_valid;
  logic [1:0]  lk_idx, deact_mask;
  logic [7:0]  lk_prio;
  logic [9:0]  lk_phys_id, deact_irq;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  virq_list_regs u_virq_list_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_cpu(rd_cpu), .rd_idx(rd_idx), .rd_data(rd_data),
    .op_kind(op_kind), .op_vcpu(op_vcpu), .op_virq(op_virq), .sec_en(sec_en),
    .phys_grp1(phys_grp1), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_prio(lk_prio),
    .lk_grp1(lk_grp1), .lk_phys_id(lk_phys_id), .eoi_ok(eoi_ok),
    .deact_valid(deact_valid), .deact_irq(deact_irq), .deact_mask(deact_mask)
  );

  typedef struct packed {
    logic [1:0] kind; logic [1:0] vcpu; logic [9:0] virq; logic sec; logic g1;
    logic e_hit; logic [1:0] e_idx; logic [7:0] e_prio; logic e_grp; logic e_eoi;
    logic e_dv; logic [9:0] e_dirq; logic [1:0] e_dmask;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{2'd0, 2'd2, 10'd40, 1'b0, 1'b0, 1'b1, 2'd0, 8'd40, 1'b1, 1'b1, 1'b0, 10'd0,   2'd0},
    '{2'd0, 2'd2, 10'd50, 1'b0, 1'b0, 1'b1, 2'd1, 8'd24, 1'b0, 1'b1, 1'b0, 10'd0,   2'd0},
    '{2'd0, 2'd3, 10'd99, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd0},
    '{2'd0, 2'd1, 10'd40, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd0},
    '{2'd3, 2'd2, 10'd50, 1'b0, 1'b0, 1'b1, 2'd1, 8'd24, 1'b0, 1'b1, 1'b1, 10'd100, 2'd3},
    '{2'd3, 2'd2, 10'd60, 1'b0, 1'b0, 1'b1, 2'd3, 8'd0,  1'b0, 1'b1, 1'b1, 10'd20,  2'd1},
    '{2'd3, 2'd3, 10'd70, 1'b0, 1'b0, 1'b1, 2'd0, 8'd0,  1'b0, 1'b1, 1'b0, 10'd0,   2'd0},
    '{2'd3, 2'd3, 10'd80, 1'b0, 1'b0, 1'b1, 2'd1, 8'd0,  1'b0, 1'b1, 1'b0, 10'd0,   2'd0},
    '{2'd3, 2'd3, 10'd90, 1'b1, 1'b0, 1'b1, 2'd2, 8'd0,  1'b0, 1'b1, 1'b0, 10'd0,   2'd0},
    '{2'd2, 2'd3, 10'd90, 1'b1, 1'b0, 1'b1, 2'd2, 8'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd0},
    '{2'd3, 2'd3, 10'd90, 1'b1, 1'b1, 1'b1, 2'd2, 8'd0,  1'b0, 1'b1, 1'b1, 10'd200, 2'd3},
    '{2'd1, 2'd2, 10'd40, 1'b0, 1'b0, 1'b1, 2'd0, 8'd40, 1'b1, 1'b1, 1'b0, 10'd0,   2'd0},
    '{2'd0, 2'd2, 10'd40, 1'b0, 1'b0, 1'b1, 2'd2, 8'd72, 1'b0, 1'b1, 1'b0, 10'd0,   2'd0},
    '{2'd3, 2'd2, 10'd40, 1'b0, 1'b0, 1'b1, 2'd2, 8'd72, 1'b0, 1'b1, 1'b0, 10'd0,   2'd0},
    '{2'd0, 2'd2, 10'd40, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd0},
    '{2'd0, 2'd2, 10'd50, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd0}
  };

  // entry image built from the field positions stated in R3
  function automatic logic [31:0] mk(input logic hw, input logic g1, input int st,
                                     input int pr, input int ph, input int vi);
    logic [31:0] r;
    r = 32'd0;
    r = r | (32'(hw) << 31) | (32'(g1) << 30) | (32'(st & 3) << 28);
    r = r | (32'(pr & 31) << 23) | (32'(ph & 1023) << 10) | 32'(vi & 1023);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int c, input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_cpu = 1'(c); wr_idx = 2'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int c, input int i, input logic [31:0] exp);
    rd_cpu = 1'(c); rd_idx = 2'(i);
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 4; i++) rd("R1 entry zero after reset", c, i, 32'd0);
    chk("R1 deact_valid after reset", 32'(deact_valid), 32'd0);
    op_vcpu = 2'd2; op_virq = 10'd0; #1;
    chk("R1 lookup miss after reset", 32'(lk_hit), 32'd0);

    wr(0, 0, mk(0, 1, 1, 5, 0, 40));
    wr(0, 1, mk(1, 0, 2, 3, 100, 50));
    wr(0, 2, mk(0, 0, 2, 9, 0, 40));
    wr(0, 3, mk(1, 0, 2, 0, 20, 60));
    wr(1, 0, mk(1, 0, 2, 0, 5, 70));
    wr(1, 1, mk(1, 0, 2, 0, 1020, 80));
    wr(1, 2, mk(1, 0, 3, 0, 200, 90));
    wr(1, 3, 32'h0070_0000 | 32'd99);
    rd("R2 reserved bits masked", 1, 3, 32'd99);
    rd("R2 readback", 0, 1, mk(1, 0, 2, 3, 100, 50));

    for (int n = 0; n < 16; n++) begin
      vec_t v;
      v = TBL[n];
      @(negedge clk);
      op_kind = v.kind; op_vcpu = v.vcpu; op_virq = v.virq; sec_en = v.sec; phys_grp1 = v.g1;
      #1;
      chk($sformatf("R3 hit step %0d", n), 32'(lk_hit), 32'(v.e_hit));
      if (v.e_hit) chk($sformatf("R3 index step %0d", n), 32'(lk_idx), 32'(v.e_idx));
      chk($sformatf("R4 priority step %0d", n), 32'(lk_prio), 32'(v.e_prio));
      chk($sformatf("R4 group step %0d", n), 32'(lk_grp1), 32'(v.e_grp));
      chk($sformatf("R5 eoi_ok step %0d", n), 32'(eoi_ok), 32'(v.e_eoi));
      @(posedge clk);
      #1;
      chk($sformatf("R8 deact_valid step %0d", n), 32'(deact_valid), 32'(v.e_dv));
      if (v.e_dv) begin
        chk($sformatf("R8 deact_irq step %0d", n), 32'(deact_irq), 32'(v.e_dirq));
        chk($sformatf("R9 deact_mask step %0d", n), 32'(deact_mask), 32'(v.e_dmask));
      end
    end
    @(negedge clk);
    op_kind = 2'd0; sec_en = 1'b0; phys_grp1 = 1'b0;
    #1;
    chk("R8 pulse ends", 32'(deact_valid), 32'd0);

    rd("R6 ack cleared pending", 0, 0, mk(0, 1, 0, 5, 0, 40));
    rd("R6 deactivate cleared active", 0, 1, mk(1, 0, 0, 3, 100, 50));
    rd("R6 state after set/clear", 1, 2, mk(1, 0, 1, 0, 200, 90));

    // R10: write and op on the same entry in one cycle
    wr(0, 0, mk(0, 0, 3, 1, 0, 33));
    @(negedge clk);
    wr_en = 1'b1; wr_cpu = 1'b0; wr_idx = 2'd0; wr_data = mk(0, 0, 3, 2, 0, 33);
    op_kind = 2'd1; op_vcpu = 2'd2; op_virq = 10'd33;
    @(negedge clk);
    wr_en = 1'b0; op_kind = 2'd0;
    rd("R10 write wins over ack", 0, 0, mk(0, 0, 3, 2, 0, 33));
    @(negedge clk);
    op_kind = 2'd1; op_virq = 10'd33;
    @(negedge clk);
    op_kind = 2'd0;
    rd("R6 lone ack", 0, 0, mk(0, 0, 2, 2, 0, 33));

    // R7: ops that miss
    @(negedge clk);
    op_kind = 2'd2; op_vcpu = 2'd2; op_virq = 10'd500;
    #1;
    chk("R7 miss on set-active", 32'(lk_hit), 32'd0);
    @(negedge clk);
    op_kind = 2'd3; op_vcpu = 2'd0; op_virq = 10'd33;
    #1;
    chk("R7 physical cpu number misses", 32'(lk_hit), 32'd0);
    @(posedge clk); #1;
    chk("R7 no forward on miss", 32'(deact_valid), 32'd0);
    @(negedge clk);
    op_kind = 2'd0;
    rd("R7 entry unchanged after miss", 0, 0, mk(0, 0, 2, 2, 0, 33));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule